// File: doc/BRIEF.md
# Register-Indirect Instruction Decoder

This is a purely combinational decoder for one 32-bit instruction format of a small CPU with eight general registers. It splits an instruction word into its fields and reports the execute class, the ALU sub-operation, whether the condition flags are updated, and where the result goes. It also gives an addressing mode for each of the two register operands and for the destination. Each mode is either a direct register or a register-indirect memory reference.

Two move opcodes share a single execute class and differ only in which side is indirect. Opcode 8 moves a register into the memory word addressed by a second register. Opcode 9 moves a memory word, addressed by a register, into a second register.

The decoder reads no registers and touches no memory. Words of any other format are reported as not handled, and every control output is then quiet.

Top module: `rid_decoder`

## Requirements
- R1: `fmtHit` is 1 exactly when bits 31:29 equal 3'b001. When it is 0, `illegal`, `flagsEn` and `dstWrite` are 0 and `execClass` is 0 (none).
- R2: `opcode` always carries bits 28:16. `regA` always carries bits 10:8 and `regB` always carries bits 2:0.
- R3: In this format, an opcode above 9 raises `illegal`.
- R4: In this format, a nonzero value in bits 15:11 or 7:3 raises `illegal`. Any illegal word drives `execClass` 0, `flagsEn` 0, `dstWrite` 0, all modes 0 (direct) and `dstReg` 0.
- R5: For legal words, `execClass` is 1 (ALU) for opcodes 0-4, 2 (halt) for 5, 3 (push) for 6, 4 (pop) for 7 and 5 (move) for 8 and 9.
- R6: `aluOp` equals the opcode (0 add, 1 subtract, 2 shift left, 3 shift right, 4 compare) for legal opcodes 0-4. It is 0 otherwise.
- R7: `flagsEn` is 1 only for legal opcodes 0-4.
- R8: Opcode 8 gives `srcAMode`=0, `srcBMode`=1, `dstWrite`=1, `dstMode`=1 (indirect) and `dstReg`=`regB`.
- R9: Opcode 9 gives `srcAMode`=1, `srcBMode`=0, `dstWrite`=1, `dstMode`=0 (direct) and `dstReg`=`regB`.
- R10: Legal opcodes 0-7 give both source modes 0. Opcodes 0-3 write `regA` directly (`dstWrite`=1, `dstMode`=0). Opcodes 4-7 have `dstWrite`=0, `dstReg`=0 and `dstMode`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word to decode |
| fmtHit | output | 1 | Word belongs to the handled format |
| opcode | output | 13 | Opcode field |
| regA | output | 3 | First register index |
| regB | output | 3 | Second register index |
| srcAMode | output | 1 | Operand A mode, 0 direct, 1 indirect |
| srcBMode | output | 1 | Operand B mode, 0 direct, 1 indirect |
| dstMode | output | 1 | Destination mode, 0 direct, 1 indirect |
| dstReg | output | 3 | Register that names the destination |
| dstWrite | output | 1 | Instruction produces a result |
| execClass | output | 3 | Execute action class |
| aluOp | output | 3 | ALU sub-operation |
| flagsEn | output | 1 | Condition flags are updated |
| illegal | output | 1 | Word in this format is not legal |

## Verification
Two checks can hit the same word. The opcode range check and the register-index range check can both fail at once. A register-index fault can also sit on a word whose opcode is a move, so the index check and the move's indirect-mode selection fall in the same cycle. The bench builds words with both faults present, and words that pair an out-of-range index with opcodes 8 and 9. It expects one `illegal` and all control outputs quiet, with no leftover indirect mode. It also builds words in other formats whose lower bits hold legal-looking opcodes, to confirm that the format check takes precedence.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [2:0] {
    EX_NONE = 3'd0,
    EX_ALU  = 3'd1,
    EX_HALT = 3'd2,
    EX_PUSH = 3'd3,
    EX_POP  = 3'd4,
    EX_MOVE = 3'd5
  } execClass_e;

  typedef struct packed {
    logic indA;
    logic indB;
    logic dstOnB;
    logic dstWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/rid_ctrl.sv
module rid_ctrl
  import rid_pkg::*;
#(
  parameter int OPC_W   = 13,
  parameter int NUM_OPS = 10
) (
  input  logic             fmtHit,
  input  logic [OPC_W-1:0] opcode,
  input  logic             idxBad,
  output ctrlStrobes_t     strobes,
  output logic [2:0]       execClass,
  output logic [2:0]       aluOp,
  output logic             flagsEn,
  output logic             illegal
);
  localparam logic [OPC_W-1:0] OP_LIMIT = OPC_W'(NUM_OPS);

  logic opLegal;
  logic run;

  always_comb begin
    opLegal   = (opcode < OP_LIMIT);
    illegal   = fmtHit & (~opLegal | idxBad);
    run       = fmtHit & opLegal & ~idxBad;
    strobes   = '0;
    execClass = EX_NONE;
    aluOp     = 3'd0;
    flagsEn   = 1'b0;
    if (run) begin
      case (opcode[3:0])
        4'd0, 4'd1, 4'd2, 4'd3: begin
          execClass        = EX_ALU;
          aluOp            = opcode[2:0];
          flagsEn          = 1'b1;
          strobes.dstWrite = 1'b1;
        end
        4'd4: begin
          execClass = EX_ALU;
          aluOp     = 3'd4;
          flagsEn   = 1'b1;
        end
        4'd5: execClass = EX_HALT;
        4'd6: execClass = EX_PUSH;
        4'd7: execClass = EX_POP;
        4'd8: begin
          execClass        = EX_MOVE;
          strobes.indB     = 1'b1;
          strobes.dstOnB   = 1'b1;
          strobes.dstWrite = 1'b1;
        end
        4'd9: begin
          execClass        = EX_MOVE;
          strobes.indA     = 1'b1;
          strobes.dstOnB   = 1'b1;
          strobes.dstWrite = 1'b1;
        end
        default: execClass = EX_NONE;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({fmtHit, opcode, idxBad})) begin
      p_flags_alu_only_r7: assert (!flagsEn || (execClass == EX_ALU && opcode < OPC_W'(5)))
        else $error("flags enabled outside ALU opcodes");
      p_move_one_side_r8: assert (execClass != EX_MOVE || (strobes.indA ^ strobes.indB))
        else $error("move without exactly one indirect side");
      p_quiet_miss_r1: assert (fmtHit || (execClass == EX_NONE && !illegal && !flagsEn))
        else $error("activity on foreign format");
    end
  end
endmodule

// File: rtl/rid_dpath.sv
module rid_dpath
  import rid_pkg::*;
#(
  parameter int               INSTR_W = 32,
  parameter int               FMT_W   = 3,
  parameter logic [FMT_W-1:0] FMT_VAL = 3'b001,
  parameter int               OPC_W   = 13,
  parameter int               REGF_W  = 8,
  parameter int               NREGS   = 8
) (
  input  logic [INSTR_W-1:0]       instrWord,
  input  ctrlStrobes_t             strobes,
  output logic                     fmtHit,
  output logic [OPC_W-1:0]         opcode,
  output logic [$clog2(NREGS)-1:0] regA,
  output logic [$clog2(NREGS)-1:0] regB,
  output logic                     idxBad,
  output logic                     srcAMode,
  output logic                     srcBMode,
  output logic                     dstMode,
  output logic [$clog2(NREGS)-1:0] dstReg
);
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [REGF_W-1:0] IDX_LIMIT = REGF_W'(NREGS);

  logic [REGF_W-1:0] fieldA;
  logic [REGF_W-1:0] fieldB;

  always_comb begin
    fmtHit   = (instrWord[INSTR_W-1 -: FMT_W] == FMT_VAL);
    opcode   = instrWord[2*REGF_W +: OPC_W];
    fieldA   = instrWord[REGF_W +: REGF_W];
    fieldB   = instrWord[0 +: REGF_W];
    regA     = fieldA[IDX_W-1:0];
    regB     = fieldB[IDX_W-1:0];
    idxBad   = (fieldA >= IDX_LIMIT) | (fieldB >= IDX_LIMIT);
    srcAMode = strobes.indA;
    srcBMode = strobes.indB;
    dstMode  = strobes.dstWrite & strobes.indB;
    if (!strobes.dstWrite)   dstReg = '0;
    else if (strobes.dstOnB) dstReg = regB;
    else                     dstReg = regA;
  end

  always_comb begin
    if (!$isunknown({instrWord, strobes})) begin
      p_single_indirect_r8: assert (!(srcAMode && srcBMode))
        else $error("both operands indirect");
      p_ind_dst_r9: assert (!dstMode || (srcBMode && dstReg == regB))
        else $error("indirect destination not tied to operand B");
    end
  end
endmodule

// File: rtl/rid_decoder.sv
module rid_decoder
  import rid_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OPC_W   = 13,
  parameter int REGF_W  = 8,
  parameter int NREGS   = 8,
  parameter int NUM_OPS = 10
) (
  input  logic [INSTR_W-1:0]       instrWord,
  output logic                     fmtHit,
  output logic [OPC_W-1:0]         opcode,
  output logic [$clog2(NREGS)-1:0] regA,
  output logic [$clog2(NREGS)-1:0] regB,
  output logic                     srcAMode,
  output logic                     srcBMode,
  output logic                     dstMode,
  output logic [$clog2(NREGS)-1:0] dstReg,
  output logic                     dstWrite,
  output logic [2:0]               execClass,
  output logic [2:0]               aluOp,
  output logic                     flagsEn,
  output logic                     illegal
);
  ctrlStrobes_t strobes;
  logic         idxBad;

  rid_dpath #(
    .INSTR_W(INSTR_W), .FMT_W(3), .FMT_VAL(3'b001),
    .OPC_W(OPC_W), .REGF_W(REGF_W), .NREGS(NREGS)
  ) u_dpath (
    .instrWord(instrWord), .strobes(strobes), .fmtHit(fmtHit),
    .opcode(opcode), .regA(regA), .regB(regB), .idxBad(idxBad),
    .srcAMode(srcAMode), .srcBMode(srcBMode), .dstMode(dstMode),
    .dstReg(dstReg)
  );

  rid_ctrl #(.OPC_W(OPC_W), .NUM_OPS(NUM_OPS)) u_ctrl (
    .fmtHit(fmtHit), .opcode(opcode), .idxBad(idxBad), .strobes(strobes),
    .execClass(execClass), .aluOp(aluOp), .flagsEn(flagsEn),
    .illegal(illegal)
  );

  assign dstWrite = strobes.dstWrite;

  always_comb begin
    if (!$isunknown(instrWord)) begin
      p_illegal_quiet_r4: assert (!illegal || (execClass == 3'd0 && !dstWrite && !flagsEn))
        else $error("illegal word left active controls");
    end
  end
endmodule

// File: tb/sim_rid_decoder.sv
module sim_rid_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord = 32'h0;
  logic        fmtHit, srcAMode, srcBMode, dstMode, dstWrite, flagsEn, illegal;
  logic [12:0] opcode;
  logic [2:0]  regA, regB, dstReg, execClass, aluOp;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rid_decoder u0 (
    .instrWord(instrWord), .fmtHit(fmtHit), .opcode(opcode), .regA(regA),
    .regB(regB), .srcAMode(srcAMode), .srcBMode(srcBMode), .dstMode(dstMode),
    .dstReg(dstReg), .dstWrite(dstWrite), .execClass(execClass),
    .aluOp(aluOp), .flagsEn(flagsEn), .illegal(illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s word=%h actual=%0h expected=%0h", req, what, instrWord, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] f, input int op,
                                     input int a, input int b);
    return {f, 13'(op), 8'(a), 8'(b)};
  endfunction

  task automatic apply(input logic [31:0] w);
    bit hit, bad, run;
    int op;
    logic [2:0] eCls, eAlu, eDst;
    logic eA, eB, eDm, eW, eF;
    @(negedge clk);
    instrWord = w;
    #1;
    hit = (w[31:29] == 3'b001);
    op  = int'(w[28:16]);
    bad = hit && (op > 9 || w[15:11] != 0 || w[7:3] != 0);
    run = hit && !bad;
    eCls = 0; eAlu = 0; eDst = 0; eA = 0; eB = 0; eDm = 0; eW = 0; eF = 0;
    if (run) begin
      if (op <= 4) begin eCls = 1; eAlu = 3'(op); eF = 1; end
      else if (op == 5) eCls = 2;
      else if (op == 6) eCls = 3;
      else if (op == 7) eCls = 4;
      else eCls = 5;
      if (op <= 3) begin eW = 1; eDst = w[10:8]; end
      if (op == 8) begin eB = 1; eW = 1; eDm = 1; eDst = w[2:0]; end
      if (op == 9) begin eA = 1; eW = 1; eDst = w[2:0]; end
    end
    chk("R1", "fmtHit", 32'(fmtHit), 32'(hit));
    chk("R2", "opcode", 32'(opcode), 32'(w[28:16]));
    chk("R2", "regA", 32'(regA), 32'(w[10:8]));
    chk("R2", "regB", 32'(regB), 32'(w[2:0]));
    chk(op > 9 ? "R3" : "R4", "illegal", 32'(illegal), 32'(bad));
    chk("R5", "execClass", 32'(execClass), 32'(eCls));
    chk("R6", "aluOp", 32'(aluOp), 32'(eAlu));
    chk("R7", "flagsEn", 32'(flagsEn), 32'(eF));
    chk(op == 9 ? "R9" : "R10", "srcAMode", 32'(srcAMode), 32'(eA));
    chk(op == 8 ? "R8" : "R10", "srcBMode", 32'(srcBMode), 32'(eB));
    chk(op == 8 ? "R8" : "R10", "dstMode", 32'(dstMode), 32'(eDm));
    chk(op >= 8 ? "R9" : "R10", "dstWrite", 32'(dstWrite), 32'(eW));
    chk(op >= 8 ? "R8" : "R10", "dstReg", 32'(dstReg), 32'(eDst));
  endtask

  initial begin
    void'($urandom(32'd20240213));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero word is a foreign format (R1)
    apply(32'h0);
    // directed: every legal opcode, mid-range indices
    for (int op = 0; op < 10; op++) apply(mk(3'b001, op, 5, 2));
    // index boundaries 0 and 7
    apply(mk(3'b001, 8, 7, 0));
    apply(mk(3'b001, 9, 0, 7));
    // R3 opcode just past the end and the top value
    apply(mk(3'b001, 10, 1, 1));
    apply(mk(3'b001, 13'h1FFF, 1, 1));
    // R4 index faults, also on the move opcodes
    apply(mk(3'b001, 8, 8, 1));
    apply(mk(3'b001, 9, 1, 8'h80));
    apply(mk(3'b001, 0, 8'hFF, 3));
    // both faults together
    apply(mk(3'b001, 12, 9, 9));
    // R1 legal-looking bodies under other formats
    for (int f = 0; f < 8; f++) if (f != 1) apply(mk(3'(f), 8, 3, 4));
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel = int'($urandom % 4);
      case (sel)
        0: apply($urandom);
        1: apply(mk(3'b001, int'($urandom % 12), int'($urandom % 8), int'($urandom % 8)));
        2: apply(mk(3'b001, int'($urandom % 10), int'($urandom % 12), int'($urandom % 12)));
        default: apply({3'b001, $urandom_range(0, 32'h1FFFFFFF)});
      endcase
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule